// File: doc/BRIEF.md
# Receive Frame Page Formatter

This block takes one received Ethernet frame, whose length is announced up front, and lays it into a packet page through a byte-wide write port. The page receives a 16-bit status word, a 16-bit byte count, the frame body, an optional 32-bit frame check value and a closing pair of bytes. The write address runs upward from 0, one byte per write. An upstream allocator hands over the page number together with the frame start. The block reports whether the frame was stored or dropped.

A frame is announced with `frm_start`, `frm_len` and `frm_page`. The block accepts it in a cycle where `frm_rdy` is high. It then pulls the frame bytes over a valid/ready stream while it writes the page. The stream can stall at any byte. When the page is complete, a one-cycle `rx_done` strobe carries the page number. A frame that cannot be stored gives a one-cycle `rx_drop` strobe and no writes.

Top module: `rx_page_formatter`

## Requirements
- R1: A start accepted while `cfg_rx_on` is 0 or `cfg_soft_rst` is 1 makes no page write. It raises `rx_drop` for one cycle, in the cycle after acceptance, and pulls no stream bytes.
- R2: Call the body size S. S is 64 when the length L is below 64, and otherwise L rounded down to even. The byte count is S+6, plus 4 when `cfg_strip_crc` is 0. A frame whose count exceeds 2048 is dropped as in R1. A count of exactly 2048 is stored.
- R3: Page bytes 0 and 1 hold the status word, low byte first. Bit 11 is set when L > 1518, bit 12 is set when L is odd, and all other bits are 0.
- R4: Page bytes 2 and 3 hold the byte count, low byte first. The number of page writes for the frame equals this count.
- R5: For L >= 64, page bytes 4 to 4+S-1 hold the first S frame bytes in order.
- R6: For L < 64, page bytes 4 to 67 hold all L frame bytes, including an odd last byte, followed by zeros.
- R7: When `cfg_strip_crc` is 0, the four bytes after the body hold a CRC-32, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. For L < 64 it covers the 64-byte padded body. Otherwise it covers all L frame bytes, including an odd last byte.
- R8: The last two page bytes are fixed by the frame length. When L >= 64 and L is odd, they are the last frame byte followed by 0x60. In all other cases they are 0x00 followed by 0x40.
- R9: Writes of one frame go to one page, at consecutive addresses starting at 0. `rx_done` with `rx_page` pulses for one cycle, in the cycle right after the last write.
- R10: While the stream has no valid byte, no write that needs a frame byte is made. The page content is the same as for a stream that never stalls.
- R11: A new start is accepted in the same cycle as the previous frame's `rx_done`.
- R12: With `cfg_strip_crc` at 1, no CRC bytes are written, and the closing pair follows the body directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_rx_on | input | 1 | receive enable |
| cfg_soft_rst | input | 1 | soft reset request; frames are refused while high |
| cfg_strip_crc | input | 1 | 1: do not store the CRC |
| frm_start | input | 1 | frame announcement, held until accepted |
| frm_len | input | LEN_W | frame length in bytes |
| frm_page | input | PAGE_W | granted page number |
| frm_rdy | output | 1 | start can be accepted this cycle |
| in_vld | input | 1 | stream byte valid |
| in_data | input | 8 | stream byte |
| in_rdy | output | 1 | block takes a stream byte this cycle |
| mem_we | output | 1 | page write strobe |
| mem_page | output | PAGE_W | page of the write |
| mem_addr | output | AW | byte offset within the page |
| mem_wdata | output | 8 | byte written |
| rx_done | output | 1 | frame stored, one cycle |
| rx_page | output | PAGE_W | page of the stored frame, valid with rx_done |
| rx_drop | output | 1 | frame refused, one cycle |

## Verification
Completion of one frame and acceptance of the next can fall in the same cycle. The `rx_done` cycle is also the cycle in which the following `frm_start` is taken. The bench provokes this by announcing three frames back to back. Each start is held while the previous frame is still being written. In the cycle where `rx_done` is seen, the bench checks that `frm_rdy` is high. The scoreboard then checks that the next frame's header writes follow on the new page, with none of the old frame's page or bytes mixed in.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_DATA, S_TAIL, S_CRC, S_FIN, S_DONE
  } fmt_state_e;

  localparam logic [7:0] CTL_ODD  = 8'h60;
  localparam logic [7:0] CTL_EVEN = 8'h40;
  localparam int         ST_LONG_BIT = 11;
  localparam int         ST_ODD_BIT  = 12;

  // one byte of the reflected CRC-32 register update
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return r;
  endfunction

  function automatic logic [15:0] rx_status(input logic [15:0] len, input logic [15:0] long_lim);
    logic [15:0] s;
    s = '0;
    s[ST_LONG_BIT] = (len > long_lim);
    s[ST_ODD_BIT]  = len[0];
    return s;
  endfunction

  function automatic logic [15:0] body_size(input logic [15:0] len, input logic [15:0] min_len);
    return (len < min_len) ? min_len : {len[15:1], 1'b0};
  endfunction

  function automatic logic [15:0] byte_count(input logic [15:0] size, input logic keep);
    return size + 16'd6 + (keep ? 16'd4 : 16'd0);
  endfunction

endpackage

// File: rtl/rxfmt_admit.sv
module rxfmt_admit
  import rxfmt_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [LEN_W-1:0] len,
  input  logic             rx_on,
  input  logic             soft_rst,
  input  logic             strip_crc,
  output logic             ok,
  output logic [15:0]      size,
  output logic [15:0]      count,
  output logic [15:0]      status,
  output logic             odd_long
);
  localparam logic [15:0] MINL = 16'(MIN_FRAME);
  localparam logic [15:0] MAXL = 16'(MAX_FRAME);
  localparam logic [15:0] LIM  = 16'(PAGE_BYTES);

  logic [15:0] len16;

  always_comb begin
    len16    = {{(16-LEN_W){1'b0}}, len};
    size     = body_size(len16, MINL);
    count    = byte_count(size, !strip_crc);
    status   = rx_status(len16, MAXL);
    odd_long = len16[0] && (len16 >= MINL);
    ok       = rx_on && !soft_rst && (count <= LIM);
  end
endmodule

// File: rtl/rxfmt_crc.sv
module rxfmt_crc
  import rxfmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_fin
);
  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '1;
    else if (en)       crc_q <= crc32_byte(crc_q, din);
  end

  assign crc_fin = ~crc_q;
endmodule

// File: rtl/rxfmt_seq.sv
module rxfmt_seq
  import rxfmt_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int AW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ok,
  input  logic [15:0]       len,
  input  logic [15:0]       size,
  input  logic [15:0]       count,
  input  logic [15:0]       status,
  input  logic              odd_long,
  input  logic              keep_crc,
  input  logic [PAGE_W-1:0] page,
  output logic              frm_rdy,
  input  logic              in_vld,
  input  logic [7:0]        in_data,
  output logic              in_rdy,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              crc_clr,
  output logic              crc_en,
  output logic [7:0]        crc_byte,
  input  logic [31:0]       crc_val,
  output logic              done,
  output logic [PAGE_W-1:0] done_page,
  output logic              drop
);
  fmt_state_e        st;
  logic [15:0]       cnt, len_q, size_q, count_q, status_q;
  logic              keep_q, odd_q, drop_q;
  logic [7:0]        tail_q;
  logic [PAGE_W-1:0] page_q;
  logic [AW-1:0]     addr_q;

  logic acc, need_in, take, wr, data_real, last_data;
  fmt_state_e after_body;

  always_comb begin
    frm_rdy    = (st == S_IDLE) || (st == S_DONE);
    acc        = start && frm_rdy;
    data_real  = (cnt < len_q);
    need_in    = ((st == S_DATA) && data_real) || (st == S_TAIL);
    take       = need_in && in_vld;
    last_data  = (cnt == size_q - 16'd1);
    after_body = keep_q ? S_CRC : S_FIN;
    wr = (st == S_HDR) || (st == S_CRC) || (st == S_FIN) ||
         ((st == S_DATA) && (!data_real || in_vld));
    mem_wdata = 8'h00;
    unique case (st)
      S_HDR: begin
        unique case (cnt[1:0])
          2'd0: mem_wdata = status_q[7:0];
          2'd1: mem_wdata = status_q[15:8];
          2'd2: mem_wdata = count_q[7:0];
          default: mem_wdata = count_q[15:8];
        endcase
      end
      S_DATA: mem_wdata = data_real ? in_data : 8'h00;
      S_CRC: begin
        unique case (cnt[1:0])
          2'd0: mem_wdata = crc_val[7:0];
          2'd1: mem_wdata = crc_val[15:8];
          2'd2: mem_wdata = crc_val[23:16];
          default: mem_wdata = crc_val[31:24];
        endcase
      end
      S_FIN: begin
        if (cnt == 16'd0) mem_wdata = odd_q ? tail_q : 8'h00;
        else              mem_wdata = odd_q ? CTL_ODD : CTL_EVEN;
      end
      default: mem_wdata = 8'h00;
    endcase
    in_rdy    = need_in;
    mem_we    = wr;
    mem_page  = page_q;
    mem_addr  = addr_q;
    crc_clr   = acc && ok;
    crc_en    = ((st == S_DATA) && wr) || ((st == S_TAIL) && take);
    crc_byte  = (st == S_TAIL) ? in_data : mem_wdata;
    done      = (st == S_DONE);
    done_page = page_q;
    drop      = drop_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; len_q <= '0; size_q <= '0; count_q <= '0;
      status_q <= '0; keep_q <= 1'b0; odd_q <= 1'b0; drop_q <= 1'b0;
      tail_q <= '0; page_q <= '0; addr_q <= '0;
    end else begin
      drop_q <= acc && !ok;
      if (wr) addr_q <= addr_q + 1'b1;
      unique case (st)
        S_HDR: if (cnt == 16'd3) begin st <= S_DATA; cnt <= '0; end
               else cnt <= cnt + 16'd1;
        S_DATA: if (wr) begin
          if (last_data) begin st <= odd_q ? S_TAIL : after_body; cnt <= '0; end
          else cnt <= cnt + 16'd1;
        end
        S_TAIL: if (take) begin tail_q <= in_data; st <= after_body; end
        S_CRC: if (cnt == 16'd3) begin st <= S_FIN; cnt <= '0; end
               else cnt <= cnt + 16'd1;
        S_FIN: if (cnt == 16'd1) begin st <= S_DONE; cnt <= '0; end
               else cnt <= cnt + 16'd1;
        default: st <= S_IDLE;
      endcase
      if (acc && ok) begin
        st <= S_HDR; cnt <= '0; addr_q <= '0;
        len_q <= len; size_q <= size; count_q <= count; status_q <= status;
        keep_q <= keep_crc; odd_q <= odd_long; page_q <= page;
      end
    end
  end

  // write offsets stay below the count written in the header
  p_addr_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (16'(addr_q) < count_q));
  // back-to-back writes of a frame use consecutive offsets
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (addr_q == $past(addr_q) + 1'b1));
  p_done_drop_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && drop));
  // stream bytes are only pulled while a frame is in flight
  p_pull_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_rdy |-> !frm_rdy);
endmodule

// File: rtl/rx_page_formatter.sv
module rx_page_formatter
  import rxfmt_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int PAGE_W     = 2,
  parameter int PAGE_BYTES = 2048,
  parameter int MIN_FRAME  = 64,
  parameter int MAX_FRAME  = 1518,
  localparam int AW        = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx_on,
  input  logic              cfg_soft_rst,
  input  logic              cfg_strip_crc,
  input  logic              frm_start,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [PAGE_W-1:0] frm_page,
  output logic              frm_rdy,
  input  logic              in_vld,
  input  logic [7:0]        in_data,
  output logic              in_rdy,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              rx_done,
  output logic [PAGE_W-1:0] rx_page,
  output logic              rx_drop
);
  logic        ok, odd_long, crc_clr, crc_en;
  logic [15:0] size, count, status, len16;
  logic [7:0]  crc_byte;
  logic [31:0] crc_val;

  assign len16 = {{(16-LEN_W){1'b0}}, frm_len};

  rxfmt_admit #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME),
                .PAGE_BYTES(PAGE_BYTES)) u_admit (
    .len(frm_len), .rx_on(cfg_rx_on), .soft_rst(cfg_soft_rst),
    .strip_crc(cfg_strip_crc), .ok(ok), .size(size), .count(count),
    .status(status), .odd_long(odd_long));

  rxfmt_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .din(crc_byte),
    .crc_fin(crc_val));

  rxfmt_seq #(.PAGE_W(PAGE_W), .AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(frm_start), .ok(ok), .len(len16),
    .size(size), .count(count), .status(status), .odd_long(odd_long),
    .keep_crc(!cfg_strip_crc), .page(frm_page), .frm_rdy(frm_rdy),
    .in_vld(in_vld), .in_data(in_data), .in_rdy(in_rdy), .mem_we(mem_we),
    .mem_page(mem_page), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .crc_clr(crc_clr), .crc_en(crc_en), .crc_byte(crc_byte), .crc_val(crc_val),
    .done(rx_done), .done_page(rx_page), .drop(rx_drop));

  // a refused frame is answered by a drop strobe and no write
  p_reject_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_start && frm_rdy && (!cfg_rx_on || cfg_soft_rst)) |=> (rx_drop && !mem_we));
  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> $stable(mem_page));
  // completion follows the closing write directly
  p_done_after_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(mem_we));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done);
endmodule

// File: tb/tb_rx_page_formatter.sv
module tb_rx_page_formatter;
  localparam int LEN_W = 12, PAGE_W = 2, AW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_rx_on = 1'b0, cfg_soft_rst = 1'b0, cfg_strip_crc = 1'b0;
  logic frm_start = 1'b0;
  logic [LEN_W-1:0] frm_len = '0;
  logic [PAGE_W-1:0] frm_page = '0;
  logic frm_rdy, in_vld, in_rdy, mem_we, rx_done, rx_drop;
  logic [7:0] in_data, mem_wdata;
  logic [PAGE_W-1:0] mem_page, rx_page;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  rx_page_formatter dut (.*);

  typedef struct { int page; int addr; int data; string tag; } wr_t;
  typedef struct { bit drop; int page; string tag; } res_t;
  wr_t exp_q[$];
  res_t res_q[$];
  logic [7:0] src_q[$];
  int checks = 0, errors = 0, tick = 0;
  bit stall_mode = 0, b2b_watch = 0, fire, finished = 0;

  task automatic chk(bit good, string req, string what, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bitwise CRC, one bit at a time
  function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [7:0] b);
    logic fb;
    for (int k = 0; k < 8; k++) begin
      fb = c[0] ^ b[k];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  task automatic push_wr(int page, int addr, int data, string tag);
    wr_t w;
    w.page = page; w.addr = addr; w.data = data; w.tag = tag;
    exp_q.push_back(w);
  endtask

  task automatic send(int len, int page, int seed);
    logic [7:0] fr[];
    int size, cnt, st, a, last;
    logic [31:0] c;
    bit keep, acc;
    res_t r;
    fr = new[len];
    for (int i = 0; i < len; i++) fr[i] = 8'((i * 13 + seed * 7 + 1) & 255);
    keep = !cfg_strip_crc;
    size = (len < 64) ? 64 : (len / 2) * 2;
    cnt = size + 6 + (keep ? 4 : 0);
    r.page = page; r.drop = 0; r.tag = "R9";
    if (!cfg_rx_on || cfg_soft_rst) begin r.drop = 1; r.tag = "R1"; end
    else if (cnt > 2048) begin r.drop = 1; r.tag = "R2"; end
    if (!r.drop) begin
      st = ((len > 1518) ? 16'h0800 : 0) | ((len % 2) ? 16'h1000 : 0);
      push_wr(page, 0, st & 255, "R3");
      push_wr(page, 1, st >> 8, "R3");
      push_wr(page, 2, cnt & 255, keep ? "R4" : "R12");
      push_wr(page, 3, cnt >> 8, keep ? "R4" : "R12");
      c = 32'hFFFFFFFF;
      for (int i = 0; i < size; i++) begin
        push_wr(page, 4 + i, (i < len) ? int'(fr[i]) : 0, (len < 64) ? "R6" : "R5");
        c = crc_bits(c, (i < len) ? fr[i] : 8'h00);
      end
      if (len >= 64 && len % 2 == 1) c = crc_bits(c, fr[len-1]);
      c = ~c;
      a = 4 + size;
      if (keep) for (int k = 0; k < 4; k++) begin
        push_wr(page, a, int'((c >> (8 * k)) & 32'hFF), "R7"); a++;
      end
      last = (len >= 64 && len % 2 == 1);
      push_wr(page, a, last ? int'(fr[len-1]) : 0, keep ? "R8" : "R12");
      push_wr(page, a + 1, last ? 'h60 : 'h40, "R8");
      for (int i = 0; i < len; i++) src_q.push_back(fr[i]);
    end
    res_q.push_back(r);
    @(posedge clk); #1;
    frm_start = 1; frm_len = LEN_W'(len); frm_page = PAGE_W'(page);
    do begin
      @(negedge clk); acc = frm_rdy;
      @(posedge clk); #1;
    end while (!acc);
    frm_start = 0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || res_q.size() != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // stream source
  initial begin
    in_vld = 0; in_data = 0;
    forever begin
      @(negedge clk); fire = in_vld && in_rdy;
      @(posedge clk); #1;
      if (fire) void'(src_q.pop_front());
      tick++;
      if (src_q.size() > 0 && !(stall_mode && tick % 3 == 0)) begin
        in_vld = 1; in_data = src_q[0];
      end else in_vld = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && !finished) begin
    if (mem_we) begin
      if (exp_q.size() == 0) chk(0, "R1", "unexpected write addr", int'(mem_addr), -1);
      else begin
        wr_t w;
        w = exp_q.pop_front();
        chk(int'(mem_page) == w.page && int'(mem_addr) == w.addr && int'(mem_wdata) == w.data,
            w.tag, $sformatf("write p%0d a%0d", w.page, w.addr),
            (int'(mem_page) << 20) | (int'(mem_addr) << 8) | int'(mem_wdata),
            (w.page << 20) | (w.addr << 8) | w.data);
      end
    end
    if (rx_done || rx_drop) begin
      if (res_q.size() == 0) chk(0, "R9", "unexpected result", {rx_done, rx_drop}, 0);
      else begin
        res_t r;
        r = res_q.pop_front();
        chk(rx_drop == r.drop && (r.drop || int'(rx_page) == r.page), r.tag, "result",
            {rx_drop, 6'b0, rx_page}, {r.drop, 6'b0, 2'(r.page)});
        if (r.drop) chk(exp_q.size() == 0, r.tag, "pending writes at drop", exp_q.size(), 0);
      end
      if (b2b_watch && rx_done) chk(frm_rdy, "R11", "rdy in done cycle", frm_rdy, 1);
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "R9", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frm_rdy && !in_rdy && !mem_we && !rx_done && !rx_drop, "R9", "reset state",
        {frm_rdy, in_rdy, mem_we, rx_done, rx_drop}, 5'b10000);
    @(posedge clk); #1; rst_n = 1; cfg_rx_on = 1;
    send(100, 1, 1); wait_idle();      // R5 R7 R8 even long
    send(101, 2, 2); wait_idle();      // R3 odd, R8 odd tail after CRC
    send(40, 0, 3);  wait_idle();      // R6 short even
    send(41, 3, 4);  wait_idle();      // R6 short odd
    cfg_strip_crc = 1;
    send(70, 1, 5);  wait_idle();      // R12
    send(63, 2, 6);  wait_idle();      // R12 with short odd
    cfg_strip_crc = 0;
    cfg_rx_on = 0; send(80, 1, 7); wait_idle();   // R1
    cfg_rx_on = 1; cfg_soft_rst = 1; send(80, 1, 8); wait_idle(); // R1
    cfg_soft_rst = 0;
    send(2040, 0, 9); wait_idle();     // R2 over limit
    send(2039, 3, 10); wait_idle();    // R2 boundary, R3 long bit, R8 odd
    send(1519, 1, 11); wait_idle();    // R3 long bit
    stall_mode = 1;
    send(81, 2, 12); wait_idle();      // R10
    send(30, 1, 13); wait_idle();      // R10 with padding
    stall_mode = 0;
    b2b_watch = 1;
    send(66, 0, 14); send(67, 1, 15); send(50, 2, 16); wait_idle();  // R11
    b2b_watch = 0;
    chk(exp_q.size() == 0 && res_q.size() == 0 && src_q.size() == 0, "R9", "drained",
        exp_q.size() + res_q.size() + src_q.size(), 0);
    finish_run();
  end
endmodule